// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block guards program and erase access to a parameterised set of memory sectors (sixteen by default). Every sector holds two state bits: a lock bit and a lock-down bit. Software changes them with a two-cycle command stream. The first cycle carries an arm code and the second carries the operation, and each cycle has its own sector address. A write-protect input turns the lock-down bit into a hardware override for the sectors that carry it.

Program and erase requests are checked against the current protection of the addressed sector. Each request gets a one-cycle grant or a one-cycle reject. Refusals and malformed command sequences leave sticky error flags in an 8-bit status word. Only the clear command removes them, and an erase suspend or resume leaves them as they are. Lock-family commands work during an erase suspend and are refused during a program suspend.

Top module: `sector_guard`

## Requirements
- R1: Reset leaves every lock bit at 1, every lock-down bit at 0 and the status word at 0x00.
- R2: The sequence 0x60 followed by 0x01 sets the lock bit of the sector addressed in the second cycle. A request to a sector whose lock bit is 1 receives `reject` one cycle later and sets status bit 1.
- R3: The sequence 0x60 followed by 0xD0 clears the addressed lock bit. A request to a sector that is not protected receives `grant` one cycle later.
- R4: The sequence 0x60 followed by 0x2F sets both the lock-down bit and the lock bit, whatever the sector's previous lock bit. Only reset clears a lock-down bit.
- R5: While `wp_assert` is 1, an unlock of a sector with its lock-down bit set has no effect, and requests to that sector are rejected even if its lock bit is 0. While `wp_assert` is 0, such a sector can be unlocked.
- R6: If the 0x60 arm code is followed by any code other than 0x01, 0xD0 or 0x2F, no lock state changes and status bits 4 and 5 are both set.
- R7: `grant` and `reject` are single-cycle pulses, one per request cycle, and never high together.
- R8: The code 0x50, given outside an armed sequence, clears status bits 1, 4 and 5.
- R9: Status bits 4 and 5 stay set across changes of `erase_susp` until a clear command arrives.
- R10: Lock, unlock and lock-down sequences take effect while `erase_susp` is 1.
- R11: While `prog_susp` is 1, a lock-family sequence changes no lock state and sets status bits 4 and 5.
- R12: A request is judged against the protection that holds before a command completing in the same cycle. An error raised in the same cycle as a clear command stays set.
- R13: Status bit 6 follows `erase_susp` and status bit 2 follows `prog_susp`, each one cycle later. Bits 0, 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command cycle valid |
| cmd_code | input | 8 | Command code |
| cmd_sector | input | SEC_W | Sector address of this command cycle |
| wp_assert | input | 1 | Hardware write protect, 1 = asserted |
| erase_susp | input | 1 | Erase suspended flag |
| prog_susp | input | 1 | Program suspended flag |
| req_valid | input | 1 | Program or erase request |
| req_sector | input | SEC_W | Sector addressed by the request |
| grant | output | 1 | Request permitted (one cycle) |
| reject | output | 1 | Request refused (one cycle) |
| status | output | 8 | Status word |
| lock_state | output | NUM_SECTORS | Lock bit per sector |
| down_state | output | NUM_SECTORS | Lock-down bit per sector |

## Verification
Two collisions matter in this block. In the first, a lock command's second step and an access request for the same sector fall in the same cycle. The bench drives both on one edge and expects a grant, because the request sees the sector state from before that edge, and it then confirms that the lock bit changed. In the second, a clear command and a refused request coincide. The bench expects status bit 1 to still be set afterwards, because the new error takes precedence over the clear.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam logic [7:0] CODE_ARM    = 8'h60;
  localparam logic [7:0] CODE_LOCK   = 8'h01;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;
  localparam logic [7:0] CODE_DOWN   = 8'h2F;
  localparam logic [7:0] CODE_CLEAR  = 8'h50;

  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_state_e;
  typedef enum logic [1:0] {OP_LOCK, OP_UNLOCK, OP_DOWN, OP_NONE} lock_op_e;

  function automatic lock_op_e decode_op(input logic [7:0] code);
    case (code)
      CODE_LOCK:   return OP_LOCK;
      CODE_UNLOCK: return OP_UNLOCK;
      CODE_DOWN:   return OP_DOWN;
      default:     return OP_NONE;
    endcase
  endfunction

  // protection seen by an access: lock bit, or lock-down held by the pin
  function automatic logic sector_protected(input logic lk, input logic dn, input logic wp);
    return lk | (dn & wp);
  endfunction

  function automatic logic unlock_allowed(input logic dn, input logic wp);
    return !(dn && wp);
  endfunction
endpackage

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import sg_pkg::*;
#(
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic             prog_susp,
  output logic             fam_step,
  output logic             op_fire,
  output lock_op_e         op_kind,
  output logic [SEC_W-1:0] op_sector,
  output logic             seq_fault,
  output logic             clr_fire
);
  seq_state_e state_q, state_d;
  lock_op_e   dec;

  always_comb begin
    dec       = decode_op(cmd_code);
    fam_step  = cmd_valid && (state_q == SEQ_ARMED) && (dec != OP_NONE);
    op_fire   = fam_step && !prog_susp;
    op_kind   = dec;
    op_sector = cmd_sector;
    seq_fault = cmd_valid && (state_q == SEQ_ARMED) && ((dec == OP_NONE) || prog_susp);
    clr_fire  = cmd_valid && (state_q == SEQ_IDLE) && (cmd_code == CODE_CLEAR);
    state_d   = state_q;
    if (cmd_valid) begin
      if (state_q == SEQ_IDLE) begin
        if (cmd_code == CODE_ARM) state_d = SEQ_ARMED;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lock_array.sv
module lock_array
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_fire,
  input  lock_op_e               op_kind,
  input  logic [SEC_W-1:0]       op_sector,
  input  logic                   wp_assert,
  output logic [NUM_SECTORS-1:0] lock_q,
  output logic [NUM_SECTORS-1:0] down_q,
  output logic [NUM_SECTORS-1:0] prot_vec
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sector
    logic hit;
    assign hit = op_fire && (op_sector == SEC_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[i] <= 1'b1;
        down_q[i] <= 1'b0;
      end else if (hit) begin
        case (op_kind)
          OP_LOCK:   lock_q[i] <= 1'b1;
          OP_UNLOCK: if (unlock_allowed(down_q[i], wp_assert)) lock_q[i] <= 1'b0;
          OP_DOWN: begin
            lock_q[i] <= 1'b1;
            down_q[i] <= 1'b1;
          end
          default: ;
        endcase
      end
    end

    assign prot_vec[i] = sector_protected(lock_q[i], down_q[i], wp_assert);
  end
endmodule

// File: rtl/access_gate.sv
module access_gate #(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [SEC_W-1:0]       req_sector,
  input  logic [NUM_SECTORS-1:0] prot_vec,
  output logic                   prot_fault,
  output logic                   grant,
  output logic                   reject
);
  // NUM_SECTORS is expected to equal 2**SEC_W so every address is a sector
  logic blocked;
  assign blocked    = prot_vec[req_sector];
  assign prot_fault = req_valid && blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      grant  <= req_valid && !blocked;
      reject <= prot_fault;
    end
  end
endmodule

// File: rtl/status_reg.sv
module status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_fault,
  input  logic       prot_fault,
  input  logic       clr_fire,
  input  logic       erase_susp,
  input  logic       prog_susp,
  output logic [7:0] status
);
  logic err_prot_q, err_seq_a_q, err_seq_b_q, es_q, ps_q;

  // a fault raised in a clear cycle outranks the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_prot_q  <= 1'b0;
      err_seq_a_q <= 1'b0;
      err_seq_b_q <= 1'b0;
      es_q        <= 1'b0;
      ps_q        <= 1'b0;
    end else begin
      err_prot_q  <= prot_fault | (err_prot_q  & ~clr_fire);
      err_seq_a_q <= seq_fault  | (err_seq_a_q & ~clr_fire);
      err_seq_b_q <= seq_fault  | (err_seq_b_q & ~clr_fire);
      es_q        <= erase_susp;
      ps_q        <= prog_susp;
    end
  end

  assign status = {1'b0, es_q, err_seq_b_q, err_seq_a_q, 1'b0, ps_q, err_prot_q, 1'b0};
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  localparam int SEC_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [7:0]             cmd_code,
  input  logic [SEC_W-1:0]       cmd_sector,
  input  logic                   wp_assert,
  input  logic                   erase_susp,
  input  logic                   prog_susp,
  input  logic                   req_valid,
  input  logic [SEC_W-1:0]       req_sector,
  output logic                   grant,
  output logic                   reject,
  output logic [7:0]             status,
  output logic [NUM_SECTORS-1:0] lock_state,
  output logic [NUM_SECTORS-1:0] down_state
);
  logic                   fam_step, op_fire, seq_fault, clr_fire, prot_fault;
  lock_op_e               op_kind;
  logic [SEC_W-1:0]       op_sector;
  logic [NUM_SECTORS-1:0] prot_vec;

  cmd_sequencer #(.SEC_W(SEC_W)) u_seq (
    .clk, .rst_n, .cmd_valid, .cmd_code, .cmd_sector, .prog_susp,
    .fam_step, .op_fire, .op_kind, .op_sector, .seq_fault, .clr_fire
  );

  lock_array #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_locks (
    .clk, .rst_n, .op_fire, .op_kind, .op_sector, .wp_assert,
    .lock_q(lock_state), .down_q(down_state), .prot_vec
  );

  access_gate #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_gate (
    .clk, .rst_n, .req_valid, .req_sector, .prot_vec,
    .prot_fault, .grant, .reject
  );

  status_reg u_stat (
    .clk, .rst_n, .seq_fault, .prot_fault, .clr_fire,
    .erase_susp, .prog_susp, .status
  );
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [7:0]             cmd_code,
  input logic                   wp_assert,
  input logic                   prog_susp,
  input logic                   req_valid,
  input logic [SEC_W-1:0]       req_sector,
  input logic                   grant,
  input logic                   reject,
  input logic [7:0]             status,
  input logic [NUM_SECTORS-1:0] lock_state,
  input logic [NUM_SECTORS-1:0] down_state,
  input logic                   fam_step
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (lock_state == '1 && down_state == '0));

  assert_locked_rejects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && lock_state[req_sector] |=> reject && status[1]);

  assert_open_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !lock_state[req_sector] && !(wp_assert && down_state[req_sector]) |=> grant);

  assert_down_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (down_state & $past(down_state)) == $past(down_state));

  assert_pin_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && wp_assert && down_state[req_sector] |=> reject);

  assert_seq_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == status[5]);

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

  assert_pulse_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || reject) |-> $past(req_valid));

  assert_seq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] && !(cmd_valid && cmd_code == 8'h50) |=> status[4]);

  assert_progsusp_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fam_step && prog_susp |=> $stable(lock_state) && $stable(down_state) && status[4]);
endmodule

bind sector_guard sector_guard_chk #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/test_sector_guard.sv
module test_sector_guard;
  localparam int N = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_code = '0;
  logic [SW-1:0] cmd_sector = '0;
  logic          wp_assert = 1'b0, erase_susp = 1'b0, prog_susp = 1'b0;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_sector = '0;
  logic          grant, reject;
  logic [7:0]    status;
  logic [N-1:0]  lock_state, down_state;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sector_guard #(.NUM_SECTORS(N)) i_sector_guard (
    .clk, .rst_n, .cmd_valid, .cmd_code, .cmd_sector, .wp_assert,
    .erase_susp, .prog_susp, .req_valid, .req_sector,
    .grant, .reject, .status, .lock_state, .down_state
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c, input logic [SW-1:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_sector = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic request(input logic [SW-1:0] s, input bit exp_grant, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_sector = s;
    exp_q.push_back(exp_grant); tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor: every response pulse is matched to one queued item
  always @(negedge clk) begin
    if (rst_n && (grant || reject)) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected response actual=%b%b expected=none", grant, reject);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (grant !== e || reject !== !e) begin
          fails++;
          $display("FAIL %s grant/reject actual=%b%b expected=%b%b", t, grant, reject, e, !e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lock", lock_state, 16'hFFFF);
    chk("R1 down", down_state, 16'h0000);
    chk("R1 status", status, 8'h00);

    // R2 locked sector refused
    request(3, 0, "R2");
    chk("R2 status", status, 8'h02);
    cmd(8'h50, 0);
    chk("R8 clear", status, 8'h00);

    // R3 unlock then grant
    cmd(8'h60, 3); cmd(8'hD0, 3);
    chk("R3 lock", lock_state, 16'hFFF7);
    request(3, 1, "R3");
    chk("R3 status", status, 8'h00);

    // R2 relock
    cmd(8'h60, 3); cmd(8'h01, 3);
    chk("R2 relock", lock_state, 16'hFFFF);
    request(3, 0, "R2");
    cmd(8'h50, 0);

    // R4 lock-down from locked (5) and from unlocked (3)
    cmd(8'h60, 5); cmd(8'h2F, 5);
    cmd(8'h60, 3); cmd(8'hD0, 3);
    cmd(8'h60, 3); cmd(8'h2F, 3);
    chk("R4 down", down_state, 16'h0028);
    chk("R4 lock", lock_state, 16'hFFFF);

    // R5 pin asserted: unlock ignored
    wp_assert = 1'b1;
    cmd(8'h60, 5); cmd(8'hD0, 5);
    chk("R5 ignored unlock", lock_state, 16'hFFFF);
    chk("R5 no error", status, 8'h00);
    request(5, 0, "R5");
    cmd(8'h50, 0);

    // R5 pin released: unlock works, lock-down kept
    wp_assert = 1'b0;
    cmd(8'h60, 5); cmd(8'hD0, 5);
    chk("R5 unlock", lock_state, 16'hFFDF);
    chk("R4 down kept", down_state, 16'h0028);
    request(5, 1, "R5");
    wp_assert = 1'b1;
    request(5, 0, "R5 pin reasserted");
    cmd(8'h50, 0);
    wp_assert = 1'b0;

    // R6 malformed sequence
    cmd(8'h60, 0); cmd(8'h77, 0);
    chk("R6 status", status, 8'h30);
    chk("R6 no change", lock_state, 16'hFFDF);
    erase_susp = 1'b1;
    @(negedge clk);
    chk("R13 erase flag", status, 8'h70);
    // R10 lock commands during erase suspend
    cmd(8'h60, 9); cmd(8'hD0, 9);
    cmd(8'h60, 5); cmd(8'h01, 5);
    chk("R10 lock", lock_state, 16'hFDFF);
    erase_susp = 1'b0;
    @(negedge clk);
    chk("R9 kept after resume", status, 8'h30);
    cmd(8'h50, 0);
    chk("R8 clear seq", status, 8'h00);

    // R11 program suspend
    prog_susp = 1'b1;
    @(negedge clk);
    chk("R13 program flag", status, 8'h04);
    cmd(8'h60, 7); cmd(8'hD0, 7);
    chk("R11 lock", lock_state, 16'hFDFF);
    chk("R11 status", status, 8'h34);
    prog_susp = 1'b0;
    cmd(8'h50, 0);
    chk("R11 cleared", status, 8'h00);

    // R12 lock completion and request on sector 9 in one cycle
    cmd(8'h60, 9);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h01; cmd_sector = 9;
    req_valid = 1'b1; req_sector = 9;
    exp_q.push_back(1'b1); tag_q.push_back("R12 old state");
    @(negedge clk);
    cmd_valid = 1'b0; req_valid = 1'b0;
    chk("R12 lock applied", lock_state, 16'hFFFF);
    request(9, 0, "R12 new state");

    // R12 clear and refusal in one cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h50; cmd_sector = 0;
    req_valid = 1'b1; req_sector = 9;
    exp_q.push_back(1'b0); tag_q.push_back("R12 clear race");
    @(negedge clk);
    cmd_valid = 1'b0; req_valid = 1'b0;
    chk("R12 error survives clear", status, 8'h02);
    cmd(8'h50, 0);
    chk("R8 final clear", status, 8'h00);

    repeat (2) @(negedge clk);
    chk("R7 queue drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule